// File: doc/BRIEF.md
# SDRAM Clock-Enable Suspend Manager

This block sits between a memory controller's command path and the clock-enable pin of a synchronous DRAM. It runs the clock suspend low-power mode. A suspend request is honoured only while a read or write burst is in progress. On entry the block pulls clock-enable low and blocks every command from upstream. The beat position of the running burst is frozen until the request is withdrawn. The block then raises clock-enable again and holds off new commands for a fixed recovery count.

The memory performs no refresh of its own while suspended, so a watchdog limits each suspend episode. The limit is the refresh period minus a configurable margin. When the limit is reached, the block forces clock-enable high and emits a one-cycle refresh-due pulse, so that the controller can schedule a refresh. A suspend request made outside an access is ignored and reported on an error pulse.

The control is a three-state machine. RUN is the normal state: commands pass and clock-enable is high. HOLD is the suspended state: clock-enable is low. RECOVER is the post-exit hold-off: clock-enable is high but commands are blocked. The transitions are as follows. Entry goes from RUN to HOLD. Release goes from HOLD to RECOVER when the request drops. Forced exit goes from HOLD to RECOVER when the watchdog expires. Resume goes from RECOVER to RUN when the recovery count is done.

Top module: `cke_suspend_mgr`

## Requirements
- R1: After reset, cke and ready are 1 and busy, cmd_out_valid, refresh_due and suspend_err are 0.
- R2: A command presented with cmd_valid while ready is 1 appears on cmd_out_valid/cmd_out_code in the next cycle, in order. The cmd_code values are 00 no-op, 01 read, 10 write and 11 other. A read or write (re)starts a burst: busy is 1 and beat counts 0 up to BURST_LEN-1, one step per clock, starting in the cycle after acceptance. No-op and other leave busy unchanged.
- R3: If suspend_req is 1 at a clock edge while busy is 1 in RUN, cke and ready are 0 from the next cycle. The beat still advances at that entry edge.
- R4: While suspended, commands are dropped and produce no cmd_out_valid, and beat and busy hold their values.
- R5: If suspend_req is 0 at an edge in HOLD, cke is 1 from the next cycle. The beat does not advance at that exit edge and resumes advancing from the next edge.
- R6: After cke returns high, ready stays 0 for RECOVERY_CYCLES cycles (default 2), and commands presented then are dropped.
- R7: A suspend request while no burst is active leaves cke at 1, and suspend_err is 1 in the cycle after each such edge.
- R8: cke stays low for at most REFRESH_CYCLES-REFRESH_MARGIN consecutive cycles (default 56). On a forced exit, cke rises together with a one-cycle refresh_due pulse.
- R9: After a forced exit, no new suspend is entered until suspend_req has been seen at 0.
- R10: A command presented at the same edge that enters suspend is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Upstream command present |
| cmd_code | input | 2 | Command: 00 no-op, 01 read, 10 write, 11 other |
| suspend_req | input | 1 | Level request to hold the memory suspended |
| cke | output | 1 | Clock-enable to the memory |
| ready | output | 1 | Upstream may present a command |
| cmd_out_valid | output | 1 | Accepted command issued to the memory |
| cmd_out_code | output | 2 | Code of the issued command |
| busy | output | 1 | A read or write burst is in progress |
| beat | output | BEAT_W | Current beat index of the burst |
| refresh_due | output | 1 | One-cycle pulse on a watchdog-forced exit |
| suspend_err | output | 1 | Pulse: suspend requested with no burst active |

## Verification
The bench targets the edges where clock-enable changes. It checks that the beat advances at the entry edge but not at the exit edge; a design that gated the counter by the next clock-enable value would be off by one beat. It holds commands asserted through suspend and recovery, and presents one at the entry edge itself; a design that leaked any of them would put an unexpected item before the scoreboard. It holds the request past the watchdog limit, then checks the exact forced-exit cycle with its refresh pulse. It then checks that a still-held request does not re-enter suspend; without the lockout the memory would fall straight back into an unrefreshed suspend.

// File: rtl/csm_pkg.sv
package csm_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RECOVER = 2'd2
    } csm_state_t;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_OTHER = 2'b11
    } csm_cmd_t;

endpackage

// File: rtl/csm_burst.sv
module csm_burst #(
    parameter int BURST_LEN = 4,
    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    output logic              busy,
    output logic [BEAT_W-1:0] beat
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    logic              busy_q;
    logic [BEAT_W-1:0] beat_q;

    // beat moves only on edges where clock-enable was high before the edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            beat_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            beat_q <= '0;
        end else if (busy_q && advance) begin
            if (beat_q == LAST_BEAT) begin
                busy_q <= 1'b0;
                beat_q <= '0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign beat = beat_q;

endmodule

// File: rtl/csm_watchdog.sv
module csm_watchdog #(
    parameter int HOLD_LIMIT = 56,
    localparam int CNT_W = $clog2(HOLD_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_hold,
    output logic expire
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !in_hold) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = in_hold && (cnt_q == LAST);

endmodule

// File: rtl/csm_fsm.sv
module csm_fsm
    import csm_pkg::*;
#(
    parameter int RECOVERY_CYCLES = 2,
    localparam int REC_W = $clog2(RECOVERY_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       suspend_req,
    input  logic       burst_busy,
    input  logic       wd_expire,
    output csm_state_t state,
    output logic       enter_hold,
    output logic       cke,
    output logic       ready,
    output logic       refresh_due,
    output logic       suspend_err
);

    localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOVERY_CYCLES - 1);

    csm_state_t       state_q, state_nx;
    logic [REC_W-1:0] rec_q;
    logic             lockout_q;
    logic             force_exit;
    logic             refresh_q;
    logic             err_q;

    always_comb begin
        enter_hold = (state_q == ST_RUN) && suspend_req && burst_busy && !lockout_q;
        force_exit = (state_q == ST_HOLD) && suspend_req && wd_expire;
        state_nx   = state_q;
        unique case (state_q)
            ST_RUN:     if (enter_hold) state_nx = ST_HOLD;
            ST_HOLD:    if (!suspend_req || wd_expire) state_nx = ST_RECOVER;
            ST_RECOVER: if (rec_q == REC_LAST) state_nx = ST_RUN;
            default:    state_nx = ST_RUN;
        endcase
    end

    // state register and the counters tied to it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            rec_q     <= '0;
            lockout_q <= 1'b0;
            refresh_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q   <= state_nx;
            rec_q     <= (state_q == ST_RECOVER) ? rec_q + 1'b1 : '0;
            refresh_q <= force_exit;
            err_q     <= (state_q == ST_RUN) && suspend_req && !burst_busy && !lockout_q;
            if (force_exit) begin
                lockout_q <= 1'b1;
            end else if (!suspend_req) begin
                lockout_q <= 1'b0;
            end
        end
    end

    // outputs decoded from the state register
    always_comb begin
        cke         = 1'b1;
        ready       = 1'b0;
        unique case (state_q)
            ST_RUN:     ready = 1'b1;
            ST_HOLD:    cke   = 1'b0;
            ST_RECOVER: ready = 1'b0;
            default:    ready = 1'b0;
        endcase
        refresh_due = refresh_q;
        suspend_err = err_q;
        state       = state_q;
    end

endmodule

// File: rtl/cke_suspend_mgr.sv
module cke_suspend_mgr
    import csm_pkg::*;
#(
    parameter int BURST_LEN       = 4,
    parameter int RECOVERY_CYCLES = 2,
    parameter int REFRESH_CYCLES  = 64,
    parameter int REFRESH_MARGIN  = 8,
    localparam int HOLD_LIMIT = REFRESH_CYCLES - REFRESH_MARGIN,
    localparam int BEAT_W     = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_code,
    input  logic              suspend_req,
    output logic              cke,
    output logic              ready,
    output logic              cmd_out_valid,
    output logic [1:0]        cmd_out_code,
    output logic              busy,
    output logic [BEAT_W-1:0] beat,
    output logic              refresh_due,
    output logic              suspend_err
);

    csm_state_t state;
    logic       enter_hold;
    logic       wd_expire;
    logic       accept;
    logic       start_burst;
    logic       out_valid_q;
    logic [1:0] out_code_q;

    csm_fsm #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .suspend_req (suspend_req),
        .burst_busy  (busy),
        .wd_expire   (wd_expire),
        .state       (state),
        .enter_hold  (enter_hold),
        .cke         (cke),
        .ready       (ready),
        .refresh_due (refresh_due),
        .suspend_err (suspend_err)
    );

    csm_watchdog #(.HOLD_LIMIT(HOLD_LIMIT)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_hold (state == ST_HOLD),
        .expire  (wd_expire)
    );

    csm_burst #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_burst),
        .advance (cke),
        .busy    (busy),
        .beat    (beat)
    );

    always_comb begin
        accept      = ready && cmd_valid && !enter_hold;
        start_burst = accept && ((csm_cmd_t'(cmd_code) == CMD_READ) ||
                                 (csm_cmd_t'(cmd_code) == CMD_WRITE));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_code_q  <= 2'b00;
        end else begin
            out_valid_q <= accept;
            if (accept) out_code_q <= cmd_code;
        end
    end

    assign cmd_out_valid = out_valid_q;
    assign cmd_out_code  = out_code_q;

endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
    parameter int RECOVERY_CYCLES = 2,
    parameter int HOLD_LIMIT      = 56,
    parameter int BEAT_W          = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              suspend_req,
    input logic              cke,
    input logic              ready,
    input logic              cmd_out_valid,
    input logic              busy,
    input logic [BEAT_W-1:0] beat,
    input logic              refresh_due,
    input logic              suspend_err
);

    localparam int SW = $clog2(RECOVERY_CYCLES + 1) + 1;
    localparam int LW = $clog2(HOLD_LIMIT + 2) + 1;

    logic [SW-1:0] since_high;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_high <= SW'(RECOVERY_CYCLES);
            low_run    <= '0;
        end else begin
            if (!cke) since_high <= '0;
            else if (since_high < SW'(RECOVERY_CYCLES)) since_high <= since_high + 1'b1;
            if (cke) low_run <= '0;
            else if (low_run <= LW'(HOLD_LIMIT)) low_run <= low_run + 1'b1;
        end
    end

    assert_enter_in_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> ($past(busy) && $past(suspend_req)));

    assert_hold_blocks_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !cmd_out_valid);

    assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cke) |-> ($stable(beat) && $stable(busy)));

    assert_recovery_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_high < SW'(RECOVERY_CYCLES)) |-> !ready);

    assert_err_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_err |-> ($past(suspend_req) && !$past(busy) && cke));

    assert_hold_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= LW'(HOLD_LIMIT));

    assert_refresh_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_due |-> (cke && $past(!cke)));

    assert_refresh_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_due |=> !refresh_due);

endmodule

bind cke_suspend_mgr csm_checker #(
    .RECOVERY_CYCLES (RECOVERY_CYCLES),
    .HOLD_LIMIT      (HOLD_LIMIT),
    .BEAT_W          (BEAT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .suspend_req   (suspend_req),
    .cke           (cke),
    .ready         (ready),
    .cmd_out_valid (cmd_out_valid),
    .busy          (busy),
    .beat          (beat),
    .refresh_due   (refresh_due),
    .suspend_err   (suspend_err)
);

// File: tb/tb_cke_suspend_mgr.sv
`timescale 1ns/1ps
module tb_cke_suspend_mgr;

    localparam int BL    = 4;
    localparam int REC   = 2;
    localparam int LIMIT = 56;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'b00;
    logic       suspend_req = 1'b0;
    logic       cke, ready, cmd_out_valid, busy, refresh_due, suspend_err;
    logic [1:0] cmd_out_code;
    logic [1:0] beat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [1:0] exp_q[$];

    always #5 clk = ~clk;

    cke_suspend_mgr #(
        .BURST_LEN(BL), .RECOVERY_CYCLES(REC),
        .REFRESH_CYCLES(64), .REFRESH_MARGIN(8)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .suspend_req(suspend_req), .cke(cke), .ready(ready),
        .cmd_out_valid(cmd_out_valid), .cmd_out_code(cmd_out_code),
        .busy(busy), .beat(beat), .refresh_due(refresh_due),
        .suspend_err(suspend_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_cmd(input logic [1:0] code, input bit expect_out);
        cmd_valid = 1'b1;
        cmd_code  = code;
        if (expect_out) exp_q.push_back(code);
        tick();
        cmd_valid = 1'b0;
    endtask

    // scoreboard monitor: every issued command must match the queue head
    always @(negedge clk) begin
        if (rst_n && cmd_out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2/R4/R6/R10 unexpected command out", 1, 0);
            end else begin
                check("R2 command code", int'(cmd_out_code), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog timeout actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 cke", int'(cke), 1);
        check("R1 ready", int'(ready), 1);
        check("R1 busy", int'(busy), 0);
        check("R1 cmd_out_valid", int'(cmd_out_valid), 0);
        check("R1 refresh_due", int'(refresh_due), 0);
        check("R1 suspend_err", int'(suspend_err), 0);
        tick();

        // R2 read burst beat sequence
        drive_cmd(2'b01, 1'b1);
        for (int i = 0; i < BL; i++) begin
            check("R2 busy in burst", int'(busy), 1);
            check("R2 beat", int'(beat), i);
            tick();
        end
        check("R2 burst done", int'(busy), 0);

        // R3/R4/R5/R6 suspend in a write burst
        drive_cmd(2'b10, 1'b1);
        check("R2 write beat0", int'(beat), 0);
        suspend_req = 1'b1;
        tick();
        check("R3 cke low", int'(cke), 0);
        check("R3 ready low", int'(ready), 0);
        check("R3 beat advanced at entry", int'(beat), 1);
        cmd_valid = 1'b1;
        cmd_code  = 2'b11;
        repeat (5) tick();
        check("R4 cke still low", int'(cke), 0);
        check("R4 beat frozen", int'(beat), 1);
        check("R4 busy frozen", int'(busy), 1);
        suspend_req = 1'b0;
        tick();
        check("R5 cke high after release", int'(cke), 1);
        check("R5 beat held at exit edge", int'(beat), 1);
        check("R6 ready low rec0", int'(ready), 0);
        tick();
        check("R6 ready low rec1", int'(ready), 0);
        check("R5 beat resumes", int'(beat), 2);
        cmd_valid = 1'b0;
        tick();
        check("R6 ready back", int'(ready), 1);
        check("R5 beat continues", int'(beat), 3);
        tick();
        check("R5 burst finishes", int'(busy), 0);

        // R7 request with no access
        suspend_req = 1'b1;
        tick();
        check("R7 cke stays high", int'(cke), 1);
        check("R7 error pulse", int'(suspend_err), 1);
        suspend_req = 1'b0;
        tick();
        check("R7 error clears", int'(suspend_err), 0);
        check("R7 ready", int'(ready), 1);

        // R8 watchdog forced exit, R9 lockout
        drive_cmd(2'b01, 1'b1);
        suspend_req = 1'b1;
        tick();
        check("R8 entered", int'(cke), 0);
        for (int i = 0; i < LIMIT - 1; i++) begin
            tick();
            check("R8 held low within limit", int'(cke), 0);
            check("R8 no early refresh_due", int'(refresh_due), 0);
        end
        tick();
        check("R8 forced cke high", int'(cke), 1);
        check("R8 refresh_due pulse", int'(refresh_due), 1);
        tick();
        check("R8 refresh_due one cycle", int'(refresh_due), 0);
        check("R6 ready low after forced exit", int'(ready), 0);
        tick();
        check("R6 ready after forced recovery", int'(ready), 1);
        drive_cmd(2'b01, 1'b1);
        check("R9 burst started", int'(busy), 1);
        check("R9 no re-entry", int'(cke), 1);
        tick();
        check("R9 no re-entry held", int'(cke), 1);
        suspend_req = 1'b0;
        tick();
        suspend_req = 1'b1;
        tick();
        check("R9 re-entry after release", int'(cke), 0);
        suspend_req = 1'b0;
        repeat (REC + 2) tick();
        check("R9 back to run", int'(ready), 1);
        repeat (BL) tick();

        // R10 command at the entry edge is dropped
        drive_cmd(2'b01, 1'b1);
        cmd_valid   = 1'b1;
        cmd_code    = 2'b11;
        suspend_req = 1'b1;
        tick();
        cmd_valid = 1'b0;
        check("R10 entered", int'(cke), 0);
        check("R10 no command out", int'(cmd_out_valid), 0);
        suspend_req = 1'b0;
        repeat (REC + 1) tick();
        check("R10 ready again", int'(ready), 1);
        repeat (BL) tick();

        // R2 mixed codes and burst restart
        drive_cmd(2'b11, 1'b1);
        check("R2 other does not start burst", int'(busy), 0);
        drive_cmd(2'b00, 1'b1);
        check("R2 nop does not start burst", int'(busy), 0);
        drive_cmd(2'b10, 1'b1);
        check("R2 write starts", int'(busy), 1);
        tick();
        check("R2 beat1", int'(beat), 1);
        drive_cmd(2'b01, 1'b1);
        check("R2 read restarts beat", int'(beat), 0);
        repeat (BL) tick();
        check("R2 restarted burst ends", int'(busy), 0);
        tick();
        check("R2 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule